// File: doc/BRIEF.md
# DMA Controller Register File

This block is the software-visible register file of a multi-channel DMA controller. The parameter `NUM_CH` sets the channel count, either 8 or 2. A simple 32-bit peripheral bus reaches it through a 4 KB window of word-aligned registers. Each channel has five words: source address, destination address, next-descriptor pointer, control and configuration. Two global words hold the controller configuration and the synchroniser setting.

The block keeps raw terminal-count and raw error flags for each channel. An external transfer engine sets these flags with one-cycle set pulses. Software clears a flag by writing a one to its bit. A flag counts toward the interrupt only when its mask bit is set, and the mask bits live in each channel's configuration word. A single level interrupt is high while any masked flag is set. A read-only identification area at the top of the window returns one byte per word. Reads return data on `bus_rdata` in the cycle after the access. A one-cycle `bus_err` pulse in that same cycle marks an access to an unmapped location.

Top module: `dmac_regs`

## Requirements
- R1: After reset, every stored register and status flag is zero, `irq_o` and `bus_err` are low, and `bus_rdata` is zero.
- R2: Channel c occupies byte offsets 0x100 + 0x20*c. Within that space, word 0 is the source, word 1 the destination, word 2 the next pointer, word 3 the control and word 4 the configuration. Each is a full 32-bit read/write register. The read value appears on `bus_rdata` in the cycle after the access, and `bus_rdata` holds its value when no read is made.
- R3: A channel access with index c >= `NUM_CH`, or to word 5..7 inside a channel's space, changes no register and reads as zero. `bus_err` is high for exactly the cycle after that access.
- R4: Offset 0x030 (global configuration) and offset 0x034 (sync) are 32-bit read/write registers.
- R5: A pulse on bit c of `tc_set_i` or `err_set_i` sets raw flag c. Offset 0x014 reads the raw terminal-count flags and offset 0x018 reads the raw error flags, each in bits [NUM_CH-1:0]. No flag is set without a pulse.
- R6: A write to 0x008 clears every raw terminal-count flag whose bit is 1 in the written data. A write to 0x010 does the same for the raw error flags. Both offsets read as zero.
- R7: When a set pulse and a clear write hit the same flag in the same cycle, the flag ends up set.
- R8: Offset 0x004 reads the raw terminal-count flags ANDed with configuration bit 15 of each channel. Offset 0x00C reads the raw error flags ANDed with configuration bit 14. Offset 0x000 reads the OR of these two values.
- R9: `irq_o` is high exactly when the value at offset 0x000 would be nonzero.
- R10: Offset 0x01C returns configuration bit 0 of channel c in bit c.
- R11: Offsets 0xFE0..0xFFC return these bytes in bits [7:0], lowest offset first: 0x80 (0x81 when `NUM_CH` is 2), 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. Writes to this area are ignored and raise no error.
- R12: Offsets 0x020..0x02C read as zero and ignore writes. Writes to the read-only status words 0x000, 0x004, 0x00C, 0x014, 0x018 and 0x01C are ignored. None of these accesses raises `bus_err`.
- R13: Every other offset (global words 14..63, 0x200..0xFDF) reads as zero, ignores writes and raises `bus_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| bus_err | output | 1 | Unmapped-access pulse, the cycle after the access |
| tc_set_i | input | NUM_CH | Terminal-count set pulses from the engine |
| err_set_i | input | NUM_CH | Error set pulses from the engine |
| irq_o | output | 1 | Level interrupt |

## Verification
The embedded properties watch four things on every cycle. A set pulse always leaves its flag set, even against a clear. A clear write drops every bit it names that had no set pulse. No flag appears without a pulse. The interrupt stays low while all mask bits are zero. They also check that `bus_err` only follows an access and that read data holds between reads. Only the bench scenarios can show the address map itself: the slot order, the aliasing of out-of-range channels, the identification bytes, the silent treatment of read-only and software-request words, and the exact masked status values.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int unsigned DW      = 32;
  localparam int unsigned AW      = 12;
  localparam int unsigned NSLOT   = 5;

  // channel slot order inside each 0x20 block
  localparam logic [2:0] SL_SRC  = 3'd0;
  localparam logic [2:0] SL_DST  = 3'd1;
  localparam logic [2:0] SL_NXT  = 3'd2;
  localparam logic [2:0] SL_CTL  = 3'd3;
  localparam logic [2:0] SL_CFG  = 3'd4;

  // global word indices
  localparam logic [3:0] GW_ANY     = 4'd0;
  localparam logic [3:0] GW_TCMSK   = 4'd1;
  localparam logic [3:0] GW_TCCLR   = 4'd2;
  localparam logic [3:0] GW_ERRMSK  = 4'd3;
  localparam logic [3:0] GW_ERRCLR  = 4'd4;
  localparam logic [3:0] GW_TCRAW   = 4'd5;
  localparam logic [3:0] GW_ERRRAW  = 4'd6;
  localparam logic [3:0] GW_ENSUM   = 4'd7;
  localparam logic [3:0] GW_GCFG    = 4'd12;
  localparam logic [3:0] GW_SYNC    = 4'd13;
  localparam logic [3:0] GW_LAST    = 4'd13;

  // configuration word bit positions
  localparam int unsigned CFGB_EN     = 0;
  localparam int unsigned CFGB_ERRMSK = 14;
  localparam int unsigned CFGB_TCMSK  = 15;

  typedef struct packed {
    logic       hit_chan;
    logic [2:0] ch;
    logic [2:0] slot;
    logic       hit_glob;
    logic [3:0] gword;
    logic       hit_id;
    logic [2:0] idx;
    logic       bad;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [2:0] i, input int unsigned nch);
    case (i)
      3'd0:    return (nch == 8) ? 8'h80 : 8'h81;
      3'd1:    return 8'h10;
      3'd2:    return 8'h04;
      3'd3:    return 8'h0A;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/dmac_addr_dec.sv
module dmac_addr_dec
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);

  always_comb begin
    dec          = '0;
    dec.ch       = addr[7:5];
    dec.slot     = addr[4:2];
    dec.gword    = addr[5:2];
    dec.idx      = addr[4:2];
    if (addr[11:8] == 4'h1) begin
      if ((int'(addr[7:5]) >= int'(NUM_CH)) || (addr[4:2] > SL_CFG)) begin
        dec.bad = 1'b1;
      end else begin
        dec.hit_chan = 1'b1;
      end
    end else if (addr[11:5] == 7'h7F) begin
      dec.hit_id = 1'b1;
    end else if (addr[11:6] == 6'd0) begin
      if (addr[5:2] > GW_LAST) begin
        dec.bad = 1'b1;
      end else begin
        dec.hit_glob = 1'b1;
      end
    end else begin
      dec.bad = 1'b1;
    end
  end

endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [2:0]                          ch,
  input  logic [2:0]                          slot,
  input  logic [DW-1:0]                       wdata,
  output logic [NUM_CH-1:0][NSLOT-1:0][DW-1:0] regs_q,
  output logic [NUM_CH-1:0]                   en_vec,
  output logic [NUM_CH-1:0]                   tc_mask,
  output logic [NUM_CH-1:0]                   err_mask
);

  logic [NUM_CH-1:0][NSLOT-1:0][DW-1:0] regs_d;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel_ch;
    assign sel_ch = wr_en && (ch == 3'(g));

    always_comb begin
      for (int s = 0; s < NSLOT; s++) begin
        regs_d[g][s] = (sel_ch && (slot == 3'(s))) ? wdata : regs_q[g][s];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (sel_ch) begin
        regs_q[g] <= regs_d[g];
      end
    end

    assign en_vec[g]   = regs_q[g][SL_CFG][CFGB_EN];
    assign tc_mask[g]  = regs_q[g][SL_CFG][CFGB_TCMSK];
    assign err_mask[g] = regs_q[g][SL_CFG][CFGB_ERRMSK];
  end

endmodule

// File: rtl/dmac_irq_stat.sv
module dmac_irq_stat #(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tc_set,
  input  logic [NUM_CH-1:0] err_set,
  input  logic              tc_clr_we,
  input  logic              err_clr_we,
  input  logic [NUM_CH-1:0] clr_bits,
  input  logic [NUM_CH-1:0] tc_mask,
  input  logic [NUM_CH-1:0] err_mask,
  output logic [NUM_CH-1:0] tc_raw,
  output logic [NUM_CH-1:0] err_raw,
  output logic [NUM_CH-1:0] tc_msk,
  output logic [NUM_CH-1:0] err_msk,
  output logic              irq
);

  logic [NUM_CH-1:0] tc_d, err_d;
  logic [NUM_CH-1:0] tc_kill, err_kill;

  always_comb begin
    tc_kill  = tc_clr_we  ? clr_bits : '0;
    err_kill = err_clr_we ? clr_bits : '0;
    // set pulses are applied after the clear, so they win
    tc_d     = (tc_raw  & ~tc_kill)  | tc_set;
    err_d    = (err_raw & ~err_kill) | err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_raw  <= '0;
      err_raw <= '0;
    end else begin
      tc_raw  <= tc_d;
      err_raw <= err_d;
    end
  end

  assign tc_msk  = tc_raw & tc_mask;
  assign err_msk = err_raw & err_mask;
  assign irq     = |{tc_msk, err_msk};

  AST_SET_PRIORITY_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_set) |=> ((tc_raw & $past(tc_set)) == $past(tc_set))); // R7
  AST_SET_PRIORITY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_set) |=> ((err_raw & $past(err_set)) == $past(err_set))); // R7
  AST_CLEAR_DROPS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    tc_clr_we |=> ((tc_raw & $past(clr_bits & ~tc_set)) == '0)); // R6
  AST_CLEAR_DROPS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr_we |=> ((err_raw & $past(clr_bits & ~err_set)) == '0)); // R6
  AST_NO_SPONTANEOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((tc_raw & ~$past(tc_raw) & ~$past(tc_set)) == '0) &&
              ((err_raw & ~$past(err_raw) & ~$past(err_set)) == '0))); // R5

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_err,
  input  logic [NUM_CH-1:0] tc_set_i,
  input  logic [NUM_CH-1:0] err_set_i,
  output logic              irq_o
);

  dec_t dec;
  logic wr_ok, rd_en, chan_we, tc_clr_we, err_clr_we, gcfg_we, sync_we;
  logic [NUM_CH-1:0][NSLOT-1:0][DW-1:0] chan_q;
  logic [NUM_CH-1:0] en_vec, tc_mask, err_mask;
  logic [NUM_CH-1:0] tc_raw, err_raw, tc_msk, err_msk;
  logic [DW-1:0] gcfg_q, gcfg_d, sync_q, sync_d, rd_d, rdata_q, chan_rd;
  logic err_d, err_q;

  dmac_addr_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  assign wr_ok      = bus_sel && bus_wr && !dec.bad;
  assign rd_en      = bus_sel && !bus_wr;
  assign chan_we    = wr_ok && dec.hit_chan;
  assign tc_clr_we  = wr_ok && dec.hit_glob && (dec.gword == GW_TCCLR);
  assign err_clr_we = wr_ok && dec.hit_glob && (dec.gword == GW_ERRCLR);
  assign gcfg_we    = wr_ok && dec.hit_glob && (dec.gword == GW_GCFG);
  assign sync_we    = wr_ok && dec.hit_glob && (dec.gword == GW_SYNC);

  dmac_chan_regs #(.NUM_CH(NUM_CH)) u_chan (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (chan_we),
    .ch       (dec.ch),
    .slot     (dec.slot),
    .wdata    (bus_wdata),
    .regs_q   (chan_q),
    .en_vec   (en_vec),
    .tc_mask  (tc_mask),
    .err_mask (err_mask)
  );

  dmac_irq_stat #(.NUM_CH(NUM_CH)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .tc_set     (tc_set_i),
    .err_set    (err_set_i),
    .tc_clr_we  (tc_clr_we),
    .err_clr_we (err_clr_we),
    .clr_bits   (bus_wdata[NUM_CH-1:0]),
    .tc_mask    (tc_mask),
    .err_mask   (err_mask),
    .tc_raw     (tc_raw),
    .err_raw    (err_raw),
    .tc_msk     (tc_msk),
    .err_msk    (err_msk),
    .irq        (irq_o)
  );

  // global registers: next state
  always_comb begin
    gcfg_d = gcfg_we ? bus_wdata : gcfg_q;
    sync_d = sync_we ? bus_wdata : sync_q;
  end

  // channel read selection without an out-of-range index
  always_comb begin
    chan_rd = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int s = 0; s < NSLOT; s++) begin
        if ((dec.ch == 3'(c)) && (dec.slot == 3'(s))) begin
          chan_rd = chan_q[c][s];
        end
      end
    end
  end

  always_comb begin
    rd_d = '0;
    if (dec.hit_chan) begin
      rd_d = chan_rd;
    end else if (dec.hit_id) begin
      rd_d = {24'd0, id_byte(dec.idx, NUM_CH)};
    end else if (dec.hit_glob) begin
      case (dec.gword)
        GW_ANY:    rd_d = 32'(tc_msk | err_msk);
        GW_TCMSK:  rd_d = 32'(tc_msk);
        GW_ERRMSK: rd_d = 32'(err_msk);
        GW_TCRAW:  rd_d = 32'(tc_raw);
        GW_ERRRAW: rd_d = 32'(err_raw);
        GW_ENSUM:  rd_d = 32'(en_vec);
        GW_GCFG:   rd_d = gcfg_q;
        GW_SYNC:   rd_d = sync_q;
        default:   rd_d = '0;
      endcase
    end
    err_d = bus_sel && dec.bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg_q  <= '0;
      sync_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (gcfg_we) gcfg_q  <= gcfg_d;
      if (sync_we) sync_q  <= sync_d;
      if (rd_en)   rdata_q <= rd_d;
      err_q <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  AST_ERR_FOLLOWS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_sel)); // R13
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R2
  AST_IRQ_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_mask == '0) && (err_mask == '0)) |-> !irq_o); // R9
  AST_BAD_WRITE_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && dec.bad && (tc_set_i == '0)) |=> (tc_raw == $past(tc_raw))); // R3

endmodule

// File: tb/tb_dmac_regs.sv
module tb_dmac_regs;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_err;
  logic [NCH-1:0] tc_set_i = '0, err_set_i = '0;
  logic irq_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_regs #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .tc_set_i(tc_set_i), .err_set_i(err_set_i), .irq_o(irq_o)
  );

  typedef struct {
    bit          chk;
    logic [31:0] data;
    logic        err;
    string       tag;
    int          due;
  } item_t;

  item_t exp_q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare results once the design has produced them
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
        item_t it;
        it = exp_q.pop_front();
        total++;
        if ((it.chk && bus_rdata !== it.data) || bus_err !== it.err) begin
          bad++;
          $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                   it.tag, bus_rdata, bus_err, it.data, it.err);
        end
      end
    end
  end

  // driver
  task automatic acc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input logic [NCH-1:0] tcs, input logic [NCH-1:0] ers,
                     input bit chk, input logic [31:0] expd, input logic experr,
                     input string tag);
    item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    tc_set_i = tcs; err_set_i = ers;
    it.chk = chk; it.data = expd; it.err = experr; it.tag = tag; it.due = cyc + 1;
    exp_q.push_back(it);
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0; tc_set_i = '0; err_set_i = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic experr, input string tag);
    acc(1'b1, a, d, '0, '0, 1'b0, '0, experr, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] expd, input logic experr, input string tag);
    acc(1'b0, a, '0, '0, '0, 1'b1, expd, experr, tag);
  endtask

  task automatic pulse(input logic [NCH-1:0] tcs, input logic [NCH-1:0] ers);
    @(negedge clk);
    tc_set_i = tcs; err_set_i = ers;
    @(posedge clk);
    #1;
    tc_set_i = '0; err_set_i = '0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    #2;
    total++;
    if (irq_o !== e) begin
      bad++;
      $display("FAIL %s: irq=%b expected %b", tag, irq_o, e);
    end
  endtask

  logic [7:0] id_exp [8];

  initial begin
    id_exp = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk); #1;
    total++;
    if (bus_rdata !== 32'd0 || bus_err !== 1'b0 || irq_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: rdata=%h err=%b irq=%b expected 0 0 0", bus_rdata, bus_err, irq_o);
    end
    rd(12'h014, 32'd0, 1'b0, "R1 raw tc after reset");
    rd(12'h100, 32'd0, 1'b0, "R1 ch0 src after reset");

    // R2 channel registers
    wr(12'h100, 32'h1000_0040, 1'b0, "R2 write src");
    wr(12'h104, 32'h2000_0080, 1'b0, "R2 write dst");
    wr(12'h108, 32'h0000_3000, 1'b0, "R2 write next");
    wr(12'h1EC, 32'h8C48_0010, 1'b0, "R2 write ch7 ctrl");
    wr(12'h170, 32'hABCD_1230, 1'b0, "R2 write ch3 cfg");
    rd(12'h100, 32'h1000_0040, 1'b0, "R2 src");
    rd(12'h104, 32'h2000_0080, 1'b0, "R2 dst");
    rd(12'h108, 32'h0000_3000, 1'b0, "R2 next");
    rd(12'h1EC, 32'h8C48_0010, 1'b0, "R2 ch7 ctrl");
    rd(12'h170, 32'hABCD_1230, 1'b0, "R2 ch3 cfg");

    // R3 invalid channel slot
    wr(12'h134, 32'hFFFF_FFFF, 1'b1, "R3 write slot5");
    rd(12'h134, 32'd0, 1'b1, "R3 read slot5");
    rd(12'h120, 32'd0, 1'b0, "R3 neighbour untouched");

    // R13 unmapped offsets
    rd(12'h200, 32'd0, 1'b1, "R13 read 0x200");
    wr(12'h040, 32'h1234_5678, 1'b1, "R13 write 0x040");
    rd(12'h03C, 32'd0, 1'b1, "R13 read word15");
    rd(12'h800, 32'd0, 1'b1, "R13 read 0x800");

    // R4 global registers
    wr(12'h030, 32'h0000_0001, 1'b0, "R4 write gcfg");
    wr(12'h034, 32'h0000_FFFF, 1'b0, "R4 write sync");
    rd(12'h030, 32'h0000_0001, 1'b0, "R4 gcfg");
    rd(12'h034, 32'h0000_FFFF, 1'b0, "R4 sync");

    // R12 software request words
    wr(12'h020, 32'h0000_00FF, 1'b0, "R12 write softreq");
    rd(12'h020, 32'd0, 1'b0, "R12 read softreq");
    rd(12'h02C, 32'd0, 1'b0, "R12 read softreq last");

    // R11 identification
    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(4*i), {24'd0, id_exp[i]}, 1'b0, "R11 id byte");
    end
    wr(12'hFE0, 32'h55, 1'b0, "R11 id write");
    rd(12'hFE0, 32'h80, 1'b0, "R11 id after write");

    // status setup
    wr(12'h110, 32'h0000_8001, 1'b0, "R8 ch0 cfg");
    wr(12'h130, 32'h0000_4000, 1'b0, "R8 ch1 cfg");
    wr(12'h1B0, 32'h0000_0001, 1'b0, "R10 ch5 cfg");
    pulse(8'h05, 8'h02);
    chk_irq(1'b1, "R9 masked flags present");
    rd(12'h014, 32'h05, 1'b0, "R5 raw tc");
    rd(12'h018, 32'h02, 1'b0, "R5 raw err");
    rd(12'h004, 32'h01, 1'b0, "R8 masked tc");
    rd(12'h00C, 32'h02, 1'b0, "R8 masked err");
    rd(12'h000, 32'h03, 1'b0, "R8 combined");
    rd(12'h01C, 32'h21, 1'b0, "R10 enable summary");

    // R6 clears
    wr(12'h008, 32'h01, 1'b0, "R6 clear tc");
    rd(12'h014, 32'h04, 1'b0, "R6 raw tc after clear");
    rd(12'h004, 32'h00, 1'b0, "R6 masked tc after clear");
    rd(12'h008, 32'h00, 1'b0, "R6 clear word reads zero");
    chk_irq(1'b1, "R9 err still masked in");
    wr(12'h010, 32'hFF, 1'b0, "R6 clear err");
    rd(12'h018, 32'h00, 1'b0, "R6 raw err after clear");
    chk_irq(1'b0, "R9 nothing masked set");

    // R7 set beats clear
    acc(1'b1, 12'h008, 32'h08, 8'h08, 8'h00, 1'b0, '0, 1'b0, "R7 tc set+clear");
    rd(12'h014, 32'h0C, 1'b0, "R7 raw tc");
    acc(1'b1, 12'h010, 32'h01, 8'h00, 8'h01, 1'b0, '0, 1'b0, "R7 err set+clear");
    rd(12'h018, 32'h01, 1'b0, "R7 raw err");
    chk_irq(1'b0, "R9 unmasked err ignored");

    // R12 read-only status write
    wr(12'h014, 32'hFFFF_FFFF, 1'b0, "R12 write raw tc");
    rd(12'h014, 32'h0C, 1'b0, "R12 raw tc unchanged");

    // mask change raises interrupt
    wr(12'h150, 32'h0000_8000, 1'b0, "R8 ch2 cfg");
    chk_irq(1'b1, "R9 mask enabled");
    rd(12'h004, 32'h04, 1'b0, "R8 masked tc ch2");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule